// File: doc/BRIEF.md
# Multi-context external interrupt controller

This block collects `NSRC` external interrupt lines and spreads them over `NCTX` receiving contexts. Each context is one privilege level on one hardware thread. Every line enters through its own gateway, which turns a level or a rising edge into a single pending request. Each source has a priority. Each context has an enable mask and a priority threshold. Every context gets one interrupt output. That output is high whenever at least one enabled, pending source has a priority above the context's threshold.

Software takes an interrupt in two steps. A claim on a context returns the best source ID and takes that source out of the pending set. A completion later hands the source back to its gateway. Until that completion arrives, the gateway forwards no new request. The `QUEUE_EDGES` parameter sets what happens to rising edges on an edge-triggered line while it waits or is in service. With the parameter set, the gateway counts those edges in a saturating counter and turns each one into a fresh request after a completion. With it clear, the gateway discards them. The context count is a parameter and may be set as large as the architecture allows (15872). The default instance is small.

Top module: `ext_irq_hub`

## Requirements
- R1: After reset every `irq_o` bit is 0 and `claim_id_o` is 0.
- R2: Configuration writes (`cfg_we`) take effect from the next clock edge. With `cfg_sel`=1, `cfg_wdata[s]` sets the enable of source s for context `cfg_idx`. A source that is disabled for a context never raises that context's `irq_o` bit and is never returned by a claim on that context.
- R3: With `cfg_sel`=0, `cfg_wdata[PRIO_W-1:0]` sets the priority of source `cfg_idx`. Among eligible sources a claim returns the one with the highest priority. On equal priority the lowest source ID wins.
- R4: With `cfg_sel`=2, `cfg_wdata[PRIO_W-1:0]` sets the threshold of context `cfg_idx`. A source is eligible only if its priority is strictly greater than that threshold. Priority 0 is therefore never eligible.
- R5: A claim (`claim_i` for one cycle) loads `claim_id_o` at that clock edge with the winning source ID of context `claim_ctx_i`, or with 0 when no source is eligible. The winner leaves the pending set in that same edge.
- R6: A level-triggered source is not pending again while it is claimed and not yet completed. After its completion it becomes pending again only if its input is still high.
- R7: With `cfg_sel`=3, `cfg_wdata[s]`=1 makes source s edge-triggered and 0 makes it level-triggered. An edge-triggered source becomes pending on a rising edge of its input, not on a held high level. A held-high input therefore gives a single request.
- R8: With `QUEUE_EDGES`=1, rising edges seen while an edge source is pending or in service are counted, saturating at 2^`CNT_W`-1. Each completion that finds the count non-zero makes the source pending again at once and lowers the count by one.
- R9: With `QUEUE_EDGES`=0, rising edges seen while an edge source is pending or in service are discarded. After completion the source stays idle until its next new rising edge.
- R10: A completion is ignored in two cases: its ID names a source that is not in service, or that source is not enabled for the completing context. The source then stays in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Interrupt inputs; bit s is source s (IDs 1..NSRC) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 priority, 1 enable mask, 2 threshold, 3 trigger mode |
| cfg_idx | input | IDX_W | Source ID (priority) or context number (enable, threshold) |
| cfg_wdata | input | NSRC+1 | Write data; bit s addresses source s, bit 0 is unused for masks |
| claim_i | input | 1 | Claim strobe |
| claim_ctx_i | input | CTX_W | Context doing the claim |
| claim_id_o | output | ID_W | Result of the last claim; 0 means none |
| done_i | input | 1 | Completion strobe |
| done_ctx_i | input | CTX_W | Context doing the completion |
| done_id_i | input | ID_W | Source ID being completed |
| irq_o | output | NCTX | One interrupt request per context |

## Verification
The hardest state to reach from the ports is a saturated edge counter being drained. The bench claims an edge source first, so that its gateway is in service. It then drives more input pulses than the counter can hold. Each completion should then make the source pending again. This must happen exactly as many times as the counter's maximum and no more. Two builds of the block share every stimulus, one queuing edges and one dropping them, so the same pulse train shows both policies side by side. Ignored completions are exposed by keeping a level source high: a wrongly accepted completion would make it pending again and raise the context's line.

// File: rtl/ext_irq_pkg.sv
// Shared definitions for the external interrupt controller.
package ext_irq_pkg;
    // Target of a configuration write.
    typedef enum logic [1:0] {
        CFG_PRIO   = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_THRESH = 2'd2,
        CFG_TRIG   = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/irq_gateway.sv
// Per-source gateway. Turns a level or a rising edge into one pending
// request. It holds off further requests while the source is in service.
// Assumes: claim_i is only raised while pending, and done_i only matters
// while busy. QUEUE_EDGES picks between counting and dropping the edges
// that arrive while pending or busy.
module irq_gateway #(
    parameter int CNT_W       = 2,
    parameter bit QUEUE_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             src_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             inc;
    logic             complete;

    assign rise     = src_i & ~src_q;
    assign complete = done_i & busy_o;
    assign inc      = QUEUE_EDGES && edge_mode_i && rise && (pend_o || busy_o) && (cnt_q != CNT_MAX);
    assign cnt_next = cnt_q + CNT_W'(inc);

    // Keep last input value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_i;
    end

    // Pending / in-service state machine with edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= edge_mode_i ? cnt_next : '0;
            if (claim_i && pend_o) begin
                pend_o <= 1'b0;
                busy_o <= 1'b1;
            end else if (complete) begin
                busy_o <= 1'b0;
                if (edge_mode_i && cnt_next != '0) begin
                    pend_o <= 1'b1;
                    cnt_q  <= cnt_next - 1'b1;
                end
            end else if (!busy_o && !pend_o) begin
                pend_o <= edge_mode_i ? rise : src_i;
            end
        end
    end

    // R6
    no_repend_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_i |=> !pend_o);
    // R5
    claim_takes_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i && pend_o |=> !pend_o && busy_o);
    generate
        if (QUEUE_EDGES) begin : g_queue_chk
            // R8
            queued_edge_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done_i && busy_o && edge_mode_i && cnt_q != '0 |=> pend_o);
        end else begin : g_drop_chk
            // R9
            dropped_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done_i && busy_o && edge_mode_i && !rise |=> !pend_o);
        end
    endgenerate
endmodule

// File: rtl/irq_ctx_select.sv
// Per-context selector. It finds the enabled pending source with the
// highest priority, where the lowest ID wins a tie. It returns that ID
// only if its priority is above the context threshold, else 0.
// Purely combinational. The clock is used by the checks only.
module irq_ctx_select #(
    parameter int NSRC   = 6,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     pend_i,
    input  logic [NSRC:1]     en_i,
    input  logic [PRIO_W-1:0] prio_i [NSRC:1],
    input  logic [PRIO_W-1:0] thr_i,
    output logic [ID_W-1:0]   grant_o
);
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // Scan upward; strict compare keeps the lowest ID on ties.
    always_comb begin
        best_p  = '0;
        best_id = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (pend_i[s] && en_i[s] && prio_i[s] > best_p) begin
                best_p  = prio_i[s];
                best_id = ID_W'(s);
            end
        end
        grant_o = (best_p > thr_i) ? best_id : '0;
    end

    // R4
    grant_clears_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o != '0 |-> prio_i[grant_o] > thr_i && prio_i[grant_o] != '0);
    // R2
    grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o != '0 |-> en_i[grant_o] && pend_i[grant_o]);
endmodule

// File: rtl/ext_irq_hub.sv
// Top of the interrupt controller. It holds the configuration registers,
// one gateway per source and one selector per context, and it runs the
// claim and completion port. Assumes one claim or completion per cycle.
module ext_irq_hub
    import ext_irq_pkg::*;
#(
    parameter int NSRC        = 6,
    parameter int NCTX        = 2,
    parameter int PRIO_W      = 3,
    parameter int CNT_W       = 2,
    parameter bit QUEUE_EDGES = 1'b1,
    parameter int ID_W        = $clog2(NSRC + 1),
    parameter int CTX_W       = (NCTX > 1) ? $clog2(NCTX) : 1,
    parameter int IDX_W       = (ID_W > CTX_W) ? ID_W : CTX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC:1]    src_i,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [NSRC:0]    cfg_wdata,
    input  logic             claim_i,
    input  logic [CTX_W-1:0] claim_ctx_i,
    output logic [ID_W-1:0]  claim_id_o,
    input  logic             done_i,
    input  logic [CTX_W-1:0] done_ctx_i,
    input  logic [ID_W-1:0]  done_id_i,
    output logic [NCTX-1:0]  irq_o
);
    logic [PRIO_W-1:0] prio_q [NSRC:1];
    logic [NSRC:1]     en_q   [NCTX];
    logic [PRIO_W-1:0] thr_q  [NCTX];
    logic [NSRC:1]     trig_q;
    logic [ID_W-1:0]   grant  [NCTX];
    logic [NSRC:1]     pend_v;
    logic [NSRC:1]     busy_v;
    logic [NSRC:1]     claim_v;
    logic [NSRC:1]     done_v;
    logic              claim_ok;
    logic              done_ok;

    assign claim_ok = int'(claim_ctx_i) < NCTX;
    assign done_ok  = int'(done_ctx_i) < NCTX;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 1; s <= NSRC; s++) prio_q[s] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
            trig_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                CFG_PRIO:
                    for (int s = 1; s <= NSRC; s++)
                        if (int'(cfg_idx) == s) prio_q[s] <= cfg_wdata[PRIO_W-1:0];
                CFG_ENABLE:
                    for (int c = 0; c < NCTX; c++)
                        if (int'(cfg_idx) == c) en_q[c] <= cfg_wdata[NSRC:1];
                CFG_THRESH:
                    for (int c = 0; c < NCTX; c++)
                        if (int'(cfg_idx) == c) thr_q[c] <= cfg_wdata[PRIO_W-1:0];
                CFG_TRIG:
                    trig_q <= cfg_wdata[NSRC:1];
            endcase
        end
    end

    // Decode claim and completion strobes onto individual sources.
    always_comb begin
        for (int s = 1; s <= NSRC; s++) begin
            claim_v[s] = claim_i && claim_ok && (int'(grant[claim_ctx_i]) == s);
            done_v[s]  = done_i && done_ok && (int'(done_id_i) == s) && en_q[done_ctx_i][s];
        end
    end

    // Register the claim result until the next claim.
    always_ff @(posedge clk) begin
        if (!rst_n)       claim_id_o <= '0;
        else if (claim_i) claim_id_o <= claim_ok ? grant[claim_ctx_i] : '0;
    end

    generate
        for (genvar s = 1; s <= NSRC; s++) begin : g_src
            irq_gateway #(.CNT_W(CNT_W), .QUEUE_EDGES(QUEUE_EDGES)) i_gw (
                .clk(clk), .rst_n(rst_n), .src_i(src_i[s]), .edge_mode_i(trig_q[s]),
                .claim_i(claim_v[s]), .done_i(done_v[s]),
                .pend_o(pend_v[s]), .busy_o(busy_v[s]));
        end
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            irq_ctx_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_sel (
                .clk(clk), .rst_n(rst_n), .pend_i(pend_v), .en_i(en_q[c]),
                .prio_i(prio_q), .thr_i(thr_q[c]), .grant_o(grant[c]));
            assign irq_o[c] = grant[c] != '0;
        end
    endgenerate

    // R5
    empty_claim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i && claim_ok && !irq_o[claim_ctx_i] |=> claim_id_o == '0);
    // R6
    pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v & busy_v) == '0);
endmodule

// File: tb/test_ext_irq_hub.sv
// Directed bench. Two builds share every stimulus: one queues edges, one drops them.
module test_ext_irq_hub;
    localparam int CLK_P = 10;
    localparam int NSRC  = 6;
    localparam int NCTX  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NSRC:1] src = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [2:0]    cfg_idx = '0;
    logic [NSRC:0] cfg_wdata = '0;
    logic          claim = 1'b0;
    logic [0:0]    claim_ctx = '0;
    logic          done = 1'b0;
    logic [0:0]    done_ctx = '0;
    logic [2:0]    done_id = '0;
    logic [2:0]    cid_q, cid_d;
    logic [1:0]    irq_q, irq_d;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    ext_irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .CNT_W(2), .QUEUE_EDGES(1'b1)) i_ext_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .claim_i(claim), .claim_ctx_i(claim_ctx),
        .claim_id_o(cid_q), .done_i(done), .done_ctx_i(done_ctx), .done_id_i(done_id),
        .irq_o(irq_q));

    ext_irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .CNT_W(2), .QUEUE_EDGES(1'b0)) i_ext_irq_hub_drop (
        .clk(clk), .rst_n(rst_n), .src_i(src), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .claim_i(claim), .claim_ctx_i(claim_ctx),
        .claim_id_o(cid_d), .done_i(done), .done_ctx_i(done_ctx), .done_id_i(done_id),
        .irq_o(irq_d));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int sel, input int idx, input int data);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = 7'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_claim(input int ctx);
        claim = 1'b1; claim_ctx = 1'(ctx);
        step();
        claim = 1'b0;
    endtask

    task automatic do_done(input int ctx, input int id);
        done = 1'b1; done_ctx = 1'(ctx); done_id = 3'(id);
        step();
        done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", int'(irq_q), 0);
        chk("R1 claim id", int'(cid_q), 0);
    endtask

    task automatic t_enable();
        src[1] = 1'b1;
        step();
        chk("R2 enabled ctx0 irq", int'(irq_q[0]), 1);
        chk("R2 masked ctx1 irq", int'(irq_q[1]), 0);
        do_claim(1);
        chk("R2 masked claim ctx1", int'(cid_q), 0);
        do_claim(0);
        chk("R5 claim ctx0", int'(cid_q), 1);
        chk("R5 pend cleared", int'(irq_q[0]), 0);
        src[1] = 1'b0;
        do_done(0, 1);
        step();
        chk("R6 low after complete", int'(irq_q[0]), 0);
    endtask

    task automatic t_priority();
        src[3:1] = 3'b111;
        step();
        do_claim(0);
        chk("R3 highest first", int'(cid_q), 2);
        do_claim(0);
        chk("R3 tie lowest id", int'(cid_q), 3);
        do_claim(0);
        chk("R3 lowest prio last", int'(cid_q), 1);
        do_claim(0);
        chk("R5 nothing eligible", int'(cid_q), 0);
        src[3:1] = 3'b000;
        do_done(0, 1); do_done(0, 2); do_done(0, 3);
        step();
        chk("R6 all quiet", int'(irq_q[0]), 0);
    endtask

    task automatic t_threshold();
        cfg(2, 0, 4);
        src[1] = 1'b1;
        step();
        chk("R4 below threshold", int'(irq_q[0]), 0);
        do_claim(0);
        chk("R4 claim below threshold", int'(cid_q), 0);
        cfg(2, 0, 1);
        chk("R4 above threshold", int'(irq_q[0]), 1);
        cfg(0, 1, 0);
        cfg(2, 0, 0);
        chk("R4 priority zero", int'(irq_q[0]), 0);
        cfg(0, 1, 2);
        do_claim(0);
        chk("R4 claim after restore", int'(cid_q), 1);
        src[1] = 1'b0;
        do_done(0, 1);
    endtask

    task automatic t_level_repend();
        src[2] = 1'b1;
        step();
        do_claim(0);
        chk("R5 level claim", int'(cid_q), 2);
        step(); step();
        chk("R6 no repend in service", int'(irq_q[0]), 0);
        do_done(0, 2);
        step();
        chk("R6 repend while high", int'(irq_q[0]), 1);
        do_claim(0);
        src[2] = 1'b0;
        do_done(0, 2);
        step();
        chk("R6 no repend when low", int'(irq_q[0]), 0);
    endtask

    task automatic t_bad_done();
        src[3] = 1'b1;
        step();
        do_claim(0);
        chk("R10 setup claim", int'(cid_q), 3);
        do_done(1, 3);
        step();
        chk("R10 done from masked ctx", int'(irq_q[0]), 0);
        do_done(0, 4);
        do_done(0, 0);
        step();
        chk("R10 done wrong id", int'(irq_q[0]), 0);
        do_done(0, 3);
        step();
        chk("R10 valid done accepted", int'(irq_q[0]), 1);
        do_claim(0);
        src[3] = 1'b0;
        do_done(0, 3);
        step();
    endtask

    task automatic t_edges();
        src[4] = 1'b1;
        step(); step(); step();
        src[4] = 1'b0;
        do_claim(0);
        chk("R7 edge claim", int'(cid_q), 4);
        chk("R7 edge claim drop build", int'(cid_d), 4);
        do_claim(0);
        chk("R7 held level single request", int'(cid_q), 0);
        for (int p = 0; p < 5; p++) begin
            src[4] = 1'b1; step();
            src[4] = 1'b0; step();
        end
        chk("R8 no pend while busy", int'(irq_q[0]), 0);
        for (int k = 0; k < 3; k++) begin
            do_done(0, 4);
            chk("R8 queued repend", int'(irq_q[0]), 1);
            chk("R9 dropped edges", int'(irq_d[0]), 0);
            do_claim(0);
            chk("R8 queued claim", int'(cid_q), 4);
            chk("R9 drop build claim", int'(cid_d), 0);
        end
        do_done(0, 4);
        step();
        chk("R8 counter saturated at 3", int'(irq_q[0]), 0);
        src[4] = 1'b1; step();
        src[4] = 1'b0; step();
        chk("R9 new edge after idle", int'(irq_d[0]), 1);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        cfg(3, 0, 7'b1110000);
        cfg(1, 0, 7'b1111110);
        cfg(1, 1, 7'b0000100);
        cfg(0, 1, 2);
        cfg(0, 2, 5);
        cfg(0, 3, 5);
        cfg(0, 4, 3);
        t_enable();
        t_priority();
        t_threshold();
        t_level_repend();
        t_bad_done();
        t_edges();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule